// File: doc/BRIEF.md
# Button-Driven Memory Browser and Byte Editor

This block gives a user read and write access to a small on-chip byte memory (256 entries of 8 bits by default) through three push buttons: up, down and enter. The button inputs are expected to be debounced already, with each press arriving as a single-cycle pulse. The block drives out the address it is pointing at, for a pair of hexadecimal digits, and a byte for a row of eight LEDs.

The block has two modes. In browse mode, up and down step the address, and the LEDs show the stored byte at that address. Pressing enter opens edit mode. On entry, a working copy of the stored byte is taken. Up and down then step that copy, and the LEDs show it. Pressing enter again writes the copy back to memory with a single-cycle write strobe and returns to browse mode. The memory is cleared by reset, so its contents are known from the first cycle.

Top module: `jram_nav_top`

## Requirements
- R1: After reset the address output is 0x00, the block is in browse mode (edit_mode = 0), mem_we is 0, and every memory entry reads 0x00.
- R2: In browse mode, an up pulse alone raises the address by one at the next clock edge, wrapping 0xFF to 0x00.
- R3: In browse mode, a down pulse alone lowers the address by one at the next clock edge, wrapping 0x00 to 0xFF.
- R4: In browse mode, enter sets edit_mode at the next edge, and led_data then shows the byte that was stored at the current address.
- R5: In edit mode, up raises and down lowers the working byte shown on led_data by one per pulse, wrapping modulo 256. mem_we stays 0 while this happens.
- R6: In edit mode, enter raises mem_we for exactly that one cycle and stores the working byte at the current address. At the next edge the block is back in browse mode, and led_data reads the new stored value.
- R7: The address output does not change while the block is in edit mode, whatever buttons are pressed.
- R8: Enter takes priority over up and down in the same cycle. Up and down asserted together, without enter, change nothing.
- R9: A write affects only the entry at the current address. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_up | input | 1 | Up pulse: next address (browse) or next data value (edit) |
| btn_down | input | 1 | Down pulse: previous address (browse) or previous data value (edit) |
| btn_enter | input | 1 | Enter pulse: open edit (browse) or commit the edit (edit) |
| cur_addr | output | ADDR_W | Current address |
| led_data | output | DATA_W | Stored byte (browse) or working byte (edit) |
| edit_mode | output | 1 | 1 while in edit mode |
| mem_we | output | 1 | Write strobe, high in the cycle the edit is committed |

## Verification
Address, mode and working-byte changes are due one clock edge after the pulse that causes them. led_data follows through the asynchronous memory read with no further delay. mem_we is combinational and is due in the same cycle as the enter pulse. The bench drives each pulse on a falling edge and samples mem_we a quarter period later, before the rising edge that acts on it. All other outputs are sampled a quarter period after that rising edge. A reference copy of the memory and the address is kept in the bench, and every entry is written and then read back by a full sweep.

// File: rtl/jram_pkg.sv
package jram_pkg;
   typedef enum logic {
      MODE_BROWSE = 1'b0,
      MODE_EDIT   = 1'b1
   } jmode_e;
endpackage

// File: rtl/jram_stepper.sv
// Wrapping +1 / -1 step unit. Opposing requests cancel.
module jram_stepper #(
   parameter int W = 8
) (
   input  logic [W-1:0] cur,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] nxt
);
   localparam logic [W-1:0] ONE = W'(1);

   generate
      if (W < 1) begin : g_bad_w
         $error("jram_stepper: W must be at least 1");
      end
   endgenerate

   always_comb begin
      nxt = cur;
      if (inc && !dec)      nxt = cur + ONE;
      else if (dec && !inc) nxt = cur - ONE;
   end
endmodule

// File: rtl/jram_store.sv
// Single-port byte store: asynchronous read, synchronous write.
module jram_store #(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_aw
         $error("jram_store: ADDR_W out of range 1..10");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("jram_store: DATA_W must be at least 1");
      end

      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[addr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[addr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[addr];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((addr != $past(addr)) || (rdata == $past(wdata)))) // R6
      else $error("write did not land");
endmodule

// File: rtl/jram_ctrl.sv
// Mode FSM, address register and working byte.
module jram_ctrl
   import jram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up,
   input  logic              down,
   input  logic              enter,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] work,
   output logic              in_edit,
   output logic              commit
);
   jmode_e            mode_q;
   logic [ADDR_W-1:0] addr_step;
   logic [DATA_W-1:0] work_step;
   logic              browse_move, edit_move;

   assign browse_move = (mode_q == MODE_BROWSE) && !enter;
   assign edit_move   = (mode_q == MODE_EDIT)   && !enter;

   jram_stepper #(.W(ADDR_W)) u_addr_step (
      .cur(addr), .inc(up & browse_move), .dec(down & browse_move), .nxt(addr_step));

   jram_stepper #(.W(DATA_W)) u_work_step (
      .cur(work), .inc(up & edit_move), .dec(down & edit_move), .nxt(work_step));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_BROWSE;
         addr   <= '0;
         work   <= '0;
      end else begin
         addr <= addr_step;
         unique case (mode_q)
            MODE_BROWSE: begin
               if (enter) begin
                  mode_q <= MODE_EDIT;
                  work   <= rd_data;
               end
            end
            MODE_EDIT: begin
               if (enter) mode_q <= MODE_BROWSE;
               else       work   <= work_step;
            end
            default: mode_q <= MODE_BROWSE;
         endcase
      end
   end

   assign in_edit = (mode_q == MODE_EDIT);
   assign commit  = in_edit && enter;

   AST_ADDR_HOLD_EDIT: assert property (@(posedge clk) disable iff (!rst_n)
      in_edit |=> $stable(addr)) // R7
      else $error("address moved in edit");
   AST_ADDR_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_edit && up && !down && !enter) |=> (addr == $past(addr) + ADDR_W'(1))) // R2
      else $error("address increment");
   AST_ADDR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_edit && down && !up && !enter) |=> (addr == $past(addr) - ADDR_W'(1))) // R3
      else $error("address decrement");
   AST_ENTER_EDIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_edit && enter) |=> (in_edit && work == $past(rd_data))) // R4
      else $error("edit entry");
   AST_COMMIT_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (!in_edit && !commit)) // R6
      else $error("commit not single");
   AST_NO_WRITE_BROWSE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_edit |-> !commit) // R5
      else $error("write outside edit");
endmodule

// File: rtl/jram_nav_top.sv
module jram_nav_top #(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              btn_up,
   input  logic              btn_down,
   input  logic              btn_enter,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] led_data,
   output logic              edit_mode,
   output logic              mem_we
);
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] work;

   jram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .up(btn_up), .down(btn_down), .enter(btn_enter),
      .rd_data(rd_data), .addr(cur_addr), .work(work), .in_edit(edit_mode),
      .commit(mem_we));

   jram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk(clk), .rst_n(rst_n), .addr(cur_addr), .we(mem_we), .wdata(work),
      .rdata(rd_data));

   assign led_data = edit_mode ? work : rd_data;

   AST_LED_BROWSE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !btn_up) |=> (led_data == $past(led_data))) // R6
      else $error("committed value not shown");
endmodule

// File: tb/jram_nav_top_tb.sv
module jram_nav_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       btn_up = 1'b0, btn_down = 1'b0, btn_enter = 1'b0;
   logic [7:0] cur_addr, led_data;
   logic       edit_mode, mem_we;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_mem [256];
   logic [7:0] exp_addr;
   logic [7:0] exp_work;
   bit         finished = 1'b0;

   always #10 clk = ~clk;

   jram_nav_top u_dut (
      .clk(clk), .rst_n(rst_n), .btn_up(btn_up), .btn_down(btn_down),
      .btn_enter(btn_enter), .cur_addr(cur_addr), .led_data(led_data),
      .edit_mode(edit_mode), .mem_we(mem_we));

   task automatic chk(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // drive at falling edge, sample mem_we before the rising edge,
   // sample the rest a quarter period after the rising edge
   task automatic press(input bit u, input bit d, input bit e, output bit we_seen);
      @(negedge clk);
      btn_up = u; btn_down = d; btn_enter = e;
      #5 we_seen = mem_we;
      @(posedge clk);
      #1 btn_up = 1'b0; btn_down = 1'b0; btn_enter = 1'b0;
      #4;
   endtask

   task automatic browse_step(input bit u);
      bit we;
      press(u, !u, 1'b0, we);
      exp_addr = u ? exp_addr + 8'd1 : exp_addr - 8'd1;
      if (u) chk("R2", cur_addr, exp_addr); else chk("R3", cur_addr, exp_addr);
      chk("R9", led_data, exp_mem[exp_addr]);
   endtask

   task automatic goto_addr(input logic [7:0] a);
      while (exp_addr != a) browse_step((a - exp_addr) < 8'd128);
   endtask

   task automatic edit_to(input logic [7:0] v);
      bit we;
      press(1'b0, 1'b0, 1'b1, we);
      chk("R4", edit_mode, 1);
      exp_work = exp_mem[exp_addr];
      chk("R4", led_data, exp_work);
      while (exp_work != v) begin
         bit u;
         u = (v - exp_work) < 8'd128;
         press(u, !u, 1'b0, we);
         exp_work = u ? exp_work + 8'd1 : exp_work - 8'd1;
         chk("R5", led_data, exp_work);
         chk("R5", we, 0);
         chk("R7", cur_addr, exp_addr);
      end
      press(1'b0, 1'b0, 1'b1, we);
      chk("R6", we, 1);
      exp_mem[exp_addr] = v;
      chk("R6", edit_mode, 0);
      chk("R6", led_data, v);
      chk("R6", mem_we, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      bit we;
      for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
      exp_addr = 8'h00;
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      #0;
      chk("R1", cur_addr, 0);
      chk("R1", edit_mode, 0);
      chk("R1", mem_we, 0);
      chk("R1", led_data, 0);
      // full upward sweep with wrap; all entries zero after reset
      for (int i = 0; i < 256; i++) begin
         browse_step(1'b1);
         chk("R1", led_data, 0);
      end
      chk("R2", cur_addr, 0);
      browse_step(1'b0);
      chk("R3", cur_addr, 8'hFF);
      browse_step(1'b1);
      // up and down together: nothing changes
      press(1'b1, 1'b1, 1'b0, we);
      chk("R8", cur_addr, exp_addr);
      chk("R8", edit_mode, 0);
      // enter with up in browse: enters edit, address kept
      press(1'b1, 1'b0, 1'b1, we);
      chk("R8", edit_mode, 1);
      chk("R8", cur_addr, exp_addr);
      press(1'b1, 1'b1, 1'b0, we);
      chk("R8", led_data, 0);
      press(1'b0, 1'b1, 1'b1, we);
      chk("R8", we, 1);
      chk("R8", edit_mode, 0);
      chk("R8", led_data, 0);
      // write every entry with a distinct value
      for (int a = 0; a < 256; a++) begin
         goto_addr(8'(a));
         edit_to(8'(a) ^ 8'h5A);
      end
      // re-edit one entry starting from its stored value, down wrap
      goto_addr(8'h10);
      edit_to(8'hF0);
      goto_addr(8'h00);
      edit_to(8'hFE);
      // read back everything
      for (int i = 0; i < 256; i++) begin
         browse_step(1'b0);
      end
      for (int a = 0; a < 256; a++) begin
         goto_addr(8'(a));
         chk("R9", led_data, exp_mem[a]);
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule